// File: doc/BRIEF.md
# Simultaneous-Hold Conversion Scheduler

This block takes three active-low hold requests, one for each channel pair (A, B and C). It places the conversions of those pairs on a single converter timeline that runs from the system clock. A falling hold edge asks the scheduler to freeze both channels of its pair, X0 and X1, and to convert them together. When several hold edges arrive in the same clock they are ordered by a fixed priority. A pair that arrives while the converter is busy waits in an ordered queue until the earlier work has finished.

Each conversion occupies a fixed slot of clock cycles. The active-low busy output is low for the first part of the slot. At the latch point the two 12-bit results of the pair are taken from stimulus input ports. The block then sends them to the output register bank as two consecutive write beats, each carrying its channel tag. The analog hold circuit and the successive-approximation decisions are not modelled here.

Top module: `hold_conv_sched`

## Requirements
- R1: While `rst_n` is low, `busy_n` is 1, `conv_cnt` is 0 and `wr_valid` is 0. A reset taken during a conversion aborts it and drops every queued pair. No write beat and no `busy_n` fall follows until a new hold edge arrives.
- R2: Each hold input passes through a two-flop synchronizer and a falling-edge detector. When the converter is idle, `busy_n` first reads 0 in the cycle after the fourth rising edge, counting the first rising edge at which `hold_n` is sampled low as the first.
- R3: Hold edges that become visible in the same cycle are converted in the order A, then B, then C. The `hold_n` bit index is 0 for A, 1 for B and 2 for C.
- R4: Hold edges that become visible in different cycles are converted in the order of their arrival.
- R5: A further falling edge on a pair that is queued or converting is ignored. After that pair's results are latched, a new edge on the same pair is accepted again.
- R6: `conv_cnt` counts 0, 1, …, 15 through a slot and rests at 0 when idle. `busy_n` is 0 exactly while `conv_cnt` is 0 to 12 of an active slot (13 cycles).
- R7: A queued pair starts exactly 16 cycles after the start of the conversion before it.
- R8: The latch happens at the end of the cycle in which `conv_cnt` is 12. `wr_valid` is then high for two cycles. The first beat (`conv_cnt` 13) carries tag X0 and the `res_x0` value sampled at the latch. The second beat (`conv_cnt` 14) carries tag X1 and the `res_x1` value sampled at the same latch. The tag codes are A0=000, A1=001, B0=010, B1=011, C0=100 and C1=101, with the pair in bits 2:1 and the sub-channel in bit 0.
- R9: A hold input kept low starts only one conversion. Only a falling edge makes a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_n | input | 3 | Active-low hold requests, bit 0 = A, 1 = B, 2 = C |
| res_x0 | input | 12 | Result for channel X0 of the converting pair |
| res_x1 | input | 12 | Result for channel X1 of the converting pair |
| busy_n | output | 1 | Low while a conversion is in progress |
| conv_cnt | output | 4 | Cycle position inside the current slot |
| wr_valid | output | 1 | Write strobe toward the output register bank |
| wr_tag | output | 3 | Channel code of the current write beat |
| wr_data | output | 12 | Result of the current write beat |

## Verification
The hardest state to reach from the ports is a full queue whose entries arrived in different cycles, with repeat pulses landing on pairs that are still pending. Because of the synchronizer, the bench shifts hold edges by single clock cycles, for example B alone and then A with C one cycle later. This puts arrival order and same-cycle priority into the queue together. The bench also fires repeat pulses during the slot, before and after the latch point, and applies a reset while two pairs are still waiting.

// File: rtl/hcs_pkg.sv
package hcs_pkg;

  localparam int RES_W = 12;

  // Channel code: pair index in the upper bits, sub-channel (0 = X0, 1 = X1) in bit 0
  function automatic logic [2:0] chan_code(input logic [1:0] pair, input logic sub);
    return {pair, sub};
  endfunction

  // One-hot mask for a pair index
  function automatic logic [2:0] pair_mask(input logic [1:0] pair);
    logic [2:0] m;
    m = '0;
    m[pair] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/hcs_hold_edge.sv
module hcs_hold_edge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hold_n,
  output logic [N-1:0] fall
);

  logic [N-1:0] s1, s2, prev;

  for (genvar g = 0; g < N; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1[g]   <= 1'b1;
        s2[g]   <= 1'b1;
        prev[g] <= 1'b1;
      end else begin
        s1[g]   <= hold_n[g];
        s2[g]   <= s1[g];
        prev[g] <= s2[g];
      end
    end
    assign fall[g] = prev[g] & ~s2[g];
  end

endmodule

// File: rtl/hcs_pair_queue.sv
module hcs_pair_queue #(
  parameter int N  = 3,
  parameter int PW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    push_mask,
  input  logic            pop,
  output logic            head_vld,
  output logic [PW-1:0]   head_pair,
  output logic [N-1:0]    q_vld,
  output logic [N*PW-1:0] q_pair_flat
);

  logic [PW-1:0] pr  [N];
  logic [PW-1:0] npr [N];
  logic [N-1:0]  vld, nvld;

  always_comb begin
    logic placed;
    nvld = vld;
    for (int i = 0; i < N; i++) npr[i] = pr[i];
    if (pop) begin
      for (int i = 0; i < N - 1; i++) begin
        nvld[i] = vld[i+1];
        npr[i]  = pr[i+1];
      end
      nvld[N-1] = 1'b0;
    end
    // append new pairs in fixed priority order (lowest index first)
    for (int p = 0; p < N; p++) begin
      placed = 1'b0;
      if (push_mask[p]) begin
        for (int i = 0; i < N; i++) begin
          if (!nvld[i] && !placed) begin
            nvld[i] = 1'b1;
            npr[i]  = PW'(p);
            placed  = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < N; i++) pr[i] <= '0;
    end else begin
      vld <= nvld;
      for (int i = 0; i < N; i++) pr[i] <= npr[i];
    end
  end

  assign head_vld  = vld[0];
  assign head_pair = pr[0];
  assign q_vld     = vld;
  for (genvar g = 0; g < N; g++) begin : g_flat
    assign q_pair_flat[g*PW +: PW] = pr[g];
  end

endmodule

// File: rtl/hcs_conv_timer.sv
module hcs_conv_timer #(
  parameter int SLOT     = 16,
  parameter int BUSY_CYC = 13,
  parameter int CW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          ready,
  output logic          latch,
  output logic          busy_n,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] LAST    = CW'(SLOT - 1);
  localparam logic [CW-1:0] LATCH_AT = CW'(BUSY_CYC - 1);
  localparam logic [CW-1:0] BUSY_END = CW'(BUSY_CYC);

  logic active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active) begin
      if (cnt == LAST) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign ready  = !active || (cnt == LAST);
  assign latch  = active && (cnt == LATCH_AT);
  assign busy_n = !(active && (cnt < BUSY_END));

endmodule

// File: rtl/hcs_result_emit.sv
module hcs_result_emit
  import hcs_pkg::*;
#(
  parameter int W = RES_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         latch,
  input  logic [1:0]   pair,
  input  logic [W-1:0] res_x0,
  input  logic [W-1:0] res_x1,
  output logic         wr_valid,
  output logic [2:0]   wr_tag,
  output logic [W-1:0] wr_data
);

  logic         second;
  logic [W-1:0] held_x1;
  logic [1:0]   held_pair;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second    <= 1'b0;
      held_x1   <= '0;
      held_pair <= '0;
      wr_valid  <= 1'b0;
      wr_tag    <= '0;
      wr_data   <= '0;
    end else if (latch) begin
      second    <= 1'b1;
      held_x1   <= res_x1;
      held_pair <= pair;
      wr_valid  <= 1'b1;
      wr_tag    <= chan_code(pair, 1'b0);
      wr_data   <= res_x0;
    end else if (second) begin
      second   <= 1'b0;
      wr_valid <= 1'b1;
      wr_tag   <= chan_code(held_pair, 1'b1);
      wr_data  <= held_x1;
    end else begin
      wr_valid <= 1'b0;
      wr_tag   <= '0;
      wr_data  <= '0;
    end
  end

endmodule

// File: rtl/hold_conv_sched.sv
module hold_conv_sched
  import hcs_pkg::*;
#(
  parameter int N_PAIRS  = 3,
  parameter int SLOT     = 16,
  parameter int BUSY_CYC = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       hold_n,
  input  logic [RES_W-1:0] res_x0,
  input  logic [RES_W-1:0] res_x1,
  output logic             busy_n,
  output logic [3:0]       conv_cnt,
  output logic             wr_valid,
  output logic [2:0]       wr_tag,
  output logic [RES_W-1:0] wr_data
);

  localparam int PW = 2;
  localparam int CW = $clog2(SLOT);

  // named internal events (observed by the bound checker)
  logic [N_PAIRS-1:0]    fall_w;
  logic [N_PAIRS-1:0]    accept_w;
  logic [N_PAIRS-1:0]    pending;
  logic [N_PAIRS-1:0]    q_vld;
  logic [N_PAIRS*PW-1:0] q_pair_flat;
  logic                  head_vld;
  logic [PW-1:0]         head_pair;
  logic                  ready_w, start_w, latch_w;
  logic [PW-1:0]         cur_pair;
  logic [CW-1:0]         cnt_w;

  hcs_hold_edge #(.N(N_PAIRS)) u_edge (
    .clk(clk), .rst_n(rst_n), .hold_n(hold_n[N_PAIRS-1:0]), .fall(fall_w)
  );

  assign accept_w = fall_w & ~pending;

  hcs_pair_queue #(.N(N_PAIRS), .PW(PW)) u_queue (
    .clk(clk), .rst_n(rst_n), .push_mask(accept_w), .pop(start_w),
    .head_vld(head_vld), .head_pair(head_pair),
    .q_vld(q_vld), .q_pair_flat(q_pair_flat)
  );

  hcs_conv_timer #(.SLOT(SLOT), .BUSY_CYC(BUSY_CYC), .CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start_w), .ready(ready_w),
    .latch(latch_w), .busy_n(busy_n), .cnt(cnt_w)
  );

  assign start_w = ready_w && head_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_pair <= '0;
      pending  <= '0;
    end else begin
      if (start_w) cur_pair <= head_pair;
      pending <= (pending | accept_w)
               & ~(latch_w ? pair_mask(cur_pair) : 3'b000);
    end
  end

  hcs_result_emit #(.W(RES_W)) u_emit (
    .clk(clk), .rst_n(rst_n), .latch(latch_w), .pair(cur_pair),
    .res_x0(res_x0), .res_x1(res_x1),
    .wr_valid(wr_valid), .wr_tag(wr_tag), .wr_data(wr_data)
  );

  assign conv_cnt = 4'(cnt_w);

endmodule

// File: rtl/hcs_checker.sv
module hcs_checker #(
  parameter int SLOT     = 16,
  parameter int BUSY_CYC = 13,
  parameter int DEPTH    = 3,
  parameter int PW       = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy_n,
  input logic [3:0]          conv_cnt,
  input logic                wr_valid,
  input logic [2:0]          wr_tag,
  input logic                latch_w,
  input logic [DEPTH-1:0]    q_vld,
  input logic [DEPTH*PW-1:0] q_pair_flat
);

  assert_busy_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> conv_cnt == 4'd0);

  assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> conv_cnt == 4'(BUSY_CYC));

  assert_latch_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    latch_w |=> wr_valid && !wr_tag[0]);

  assert_beat_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_tag[0]) |=> wr_valid && wr_tag[0] && wr_tag[2:1] == $past(wr_tag[2:1]));

  assert_tag_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_tag[2:1] != 2'b11);

  for (genvar i = 0; i < DEPTH; i++) begin : g_i
    for (genvar j = i + 1; j < DEPTH; j++) begin : g_j
      assert_queue_nodup_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q_vld[i] && q_vld[j]) |-> q_pair_flat[i*PW +: PW] != q_pair_flat[j*PW +: PW]);
    end
  end

endmodule

bind hold_conv_sched hcs_checker #(
  .SLOT(SLOT), .BUSY_CYC(BUSY_CYC), .DEPTH(N_PAIRS), .PW(PW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_n(busy_n), .conv_cnt(conv_cnt),
  .wr_valid(wr_valid), .wr_tag(wr_tag), .latch_w(latch_w),
  .q_vld(q_vld), .q_pair_flat(q_pair_flat)
);

// File: tb/test_hold_conv_sched.sv
module test_hold_conv_sched;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  hold_n = 3'b111;
  logic [11:0] res_x0 = '0;
  logic [11:0] res_x1 = '0;
  logic        busy_n;
  logic [3:0]  conv_cnt;
  logic        wr_valid;
  logic [2:0]  wr_tag;
  logic [11:0] wr_data;

  hold_conv_sched i_hold_conv_sched (
    .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .res_x0(res_x0), .res_x1(res_x1),
    .busy_n(busy_n), .conv_cnt(conv_cnt), .wr_valid(wr_valid), .wr_tag(wr_tag),
    .wr_data(wr_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  int bf_cyc [32];
  int n_bf = 0;
  logic [2:0] ev_tag [32];
  int ev_cyc [32];
  int n_ev = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // cycle counter and result stimulus, changed just after each rising edge
  initial forever begin
    @(posedge clk);
    cyc++;
    #1;
    res_x0 = 12'((cyc * 37) + 5);
    res_x1 = 12'((cyc * 91) + 1000);
  end

  // monitor: busy falls, write beats and their data (R8)
  initial begin
    logic prev_busy;
    logic [11:0] px0_1, px1_1, px1_2;
    prev_busy = 1'b1; px0_1 = '0; px1_1 = '0; px1_2 = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_busy && !busy_n && n_bf < 32) begin
          bf_cyc[n_bf] = cyc; n_bf++;
        end
        if (wr_valid && n_ev < 32) begin
          ev_tag[n_ev] = wr_tag; ev_cyc[n_ev] = cyc; n_ev++;
          if (wr_tag[0]) check(wr_data == px1_2, "R8 X1 data", wr_data, px1_2);
          else           check(wr_data == px0_1, "R8 X0 data", wr_data, px0_1);
        end
      end
      prev_busy = busy_n;
      px1_2 = px1_1; px1_1 = res_x1; px0_1 = res_x0;
    end
  end

  task automatic clear_log();
    @(negedge clk); #1;
    n_bf = 0; n_ev = 0;
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic pulse(input logic [2:0] m, output int c);
    @(negedge clk);
    c = cyc;
    hold_n = hold_n & ~m;
    repeat (2) @(negedge clk);
    hold_n = hold_n | m;
  endtask

  task automatic check_tags(input logic [2:0] exp [6], input int n, input string req);
    check(n_ev == n, req, n_ev, n);
    for (int i = 0; i < n && i < n_ev; i++)
      check(ev_tag[i] == exp[i], req, ev_tag[i], exp[i]);
  endtask

  task automatic t_reset();
    #1;
    check(busy_n == 1'b1, "R1 reset busy_n", busy_n, 1);
    check(conv_cnt == 4'd0, "R1 reset conv_cnt", conv_cnt, 0);
    check(wr_valid == 1'b0, "R1 reset wr_valid", wr_valid, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_single();
    int c;
    clear_log();
    pulse(3'b010, c);
    wait_to(c + 10);
    check(conv_cnt == 4'd6, "R6 conv_cnt mid-slot", conv_cnt, 6);
    wait_to(c + 16);
    check(busy_n == 1'b0, "R6 busy_n low at count 12", busy_n, 0);
    wait_to(c + 17);
    check(busy_n == 1'b1, "R6 busy_n high at count 13", busy_n, 1);
    wait_to(c + 40);
    check(n_bf == 1 && bf_cyc[0] == c + 4, "R2 start latency", bf_cyc[0] - c, 4);
    check(n_ev == 2, "R8 beat count", n_ev, 2);
    check(ev_tag[0] == 3'b010 && ev_cyc[0] == c + 17, "R8 first beat B0", ev_cyc[0] - c, 17);
    check(ev_tag[1] == 3'b011 && ev_cyc[1] == c + 18, "R8 second beat B1", ev_cyc[1] - c, 18);
  endtask

  task automatic t_same_cycle();
    int c;
    logic [2:0] e [6];
    e = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b100, 3'b101};
    clear_log();
    pulse(3'b111, c);
    wait_to(c + 70);
    check(n_bf == 3, "R7 three starts", n_bf, 3);
    check(bf_cyc[1] - bf_cyc[0] == 16, "R7 spacing 1", bf_cyc[1] - bf_cyc[0], 16);
    check(bf_cyc[2] - bf_cyc[1] == 16, "R7 spacing 2", bf_cyc[2] - bf_cyc[1], 16);
    check_tags(e, 6, "R3 A>B>C order");
  endtask

  task automatic t_arrival();
    logic [2:0] e [6];
    e = '{3'b010, 3'b011, 3'b000, 3'b001, 3'b100, 3'b101};
    clear_log();
    @(negedge clk); hold_n[1] = 1'b0;
    @(negedge clk); hold_n[0] = 1'b0; hold_n[2] = 1'b0;
    @(negedge clk); hold_n[1] = 1'b1;
    @(negedge clk); hold_n = 3'b111;
    repeat (70) @(negedge clk);
    check_tags(e, 6, "R4 arrival order B,A,C");
  endtask

  task automatic t_repeat();
    int c, c2, c3;
    clear_log();
    pulse(3'b001, c);
    wait_to(c + 7);
    pulse(3'b001, c2);
    wait_to(c + 30);
    check(n_bf == 1, "R5 repeat while pending ignored", n_bf, 1);
    check(n_ev == 2, "R5 single result pair", n_ev, 2);
    pulse(3'b001, c3);
    wait_to(c3 + 30);
    check(n_bf == 2 && bf_cyc[1] == c3 + 4, "R5 accepted after latch", bf_cyc[1] - c3, 4);
  endtask

  task automatic t_level();
    int c;
    clear_log();
    @(negedge clk); c = cyc; hold_n[2] = 1'b0;
    wait_to(c + 60);
    hold_n[2] = 1'b1;
    wait_to(c + 90);
    check(n_bf == 1, "R9 held level converts once", n_bf, 1);
  endtask

  task automatic t_abort();
    int c, c2;
    clear_log();
    pulse(3'b111, c);
    wait_to(c + 10);
    rst_n = 1'b0;
    #1;
    check(busy_n == 1'b1, "R1 abort busy_n", busy_n, 1);
    check(conv_cnt == 4'd0, "R1 abort conv_cnt", conv_cnt, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (60) @(negedge clk);
    check(n_bf == 1, "R1 queue cancelled", n_bf, 1);
    check(n_ev == 0, "R1 no writes after abort", n_ev, 0);
    pulse(3'b001, c2);
    wait_to(c2 + 30);
    check(n_bf == 2 && bf_cyc[1] == c2 + 4, "R1 first hold after reset", bf_cyc[1] - c2, 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_same_cycle();
    t_arrival();
    t_repeat();
    t_level();
    t_abort();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule